// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block tracks the operating context of a simple processor bus interface (ordinary execution, system-management execution, or halted) and steps it into a clock-stopped grant state whenever a stop-clock request is raised. When the request drops, the controller returns to the recorded entry context. A halted core goes back to halt, not to execution. While stopped, the core clock enable is low and the data bus and its parity lanes are floated.

While halted or stopped, the controller still serves external cache snoops. An accepted snoop strobe moves it into a short inquire sub-state. One clock later it samples an external tag lookup and reports a clean hit or a dirty hit. After a dirty hit it requests a writeback of a fixed length, either at once or after the bus is released. When the inquire finishes, the controller resumes the state it left. An init request seen while stopped is held back and acted on only after the stop request is released. Reset overrides everything.

Top module: `stopclk_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `state_out` is 0 (run), `core_clk_en` is 1, every bit of `dbus_oe` and `par_oe` is 1, and `hit_out`, `hitm_out`, `wb_req` and `init_act` are 0.
- R2: From run (0), system-management (1) or halt (2), a high `stop_req` moves `state_out` to stop-grant (3) at the next edge. `core_clk_en` is 1 only in states 0 and 1.
- R3: In stop-grant with `stop_req` low and no accepted snoop, the next state is the recorded entry state: 0, 1 or 2.
- R4: While in stop-grant, or in inquire entered from stop-grant, all bits of `dbus_oe` and `par_oe` are 0 unless `wb_req` is high. In every other case they are all 1.
- R5: Outside stop-grant, `init_act` is `init_req` delayed by one cycle. An `init_req` seen in stop-grant, or in the cycle that enters it, produces no pulse there. Instead, `init_act` is high for exactly one cycle right after stop-grant is left on release.
- R6: `rst` forces state 0 from any state, including inquire, at the next edge. It clears a deferred init, so no `init_act` follows the next stop-grant exit.
- R7: A high `snoop_strobe` is accepted only in halt or stop-grant, and only while at least one of `ahold`, `boff`, `hlda` is high. It then moves the state to inquire (4) at the next edge. Otherwise it changes no output.
- R8: If the lookup sampled one edge after the accepted strobe is a miss (`tag_hit` 0), `hit_out` and `hitm_out` stay 0. The state returns to its entry state at the second edge after the strobe.
- R9: For a clean hit (`tag_hit` 1, `tag_dirty` 0), `hit_out` is high for exactly the one cycle between the lookup edge and the return edge. The return timing matches R8.
- R10: For a dirty hit (`tag_hit` 1, `tag_dirty` 1) with `ahold` high at the strobe, `hitm_out` and `wb_req` rise at the lookup edge. `wb_req` stays high for WB_CYC cycles (default 4). At the edge where both fall, the state returns to its entry state.
- R11: For a dirty hit taken under `boff` or `hlda` (with `ahold` low), `hitm_out` rises at the lookup edge but `wb_req` stays low until `boff` and `hlda` are both low. The writeback then runs as in R10.
- R12: From run, a high `halt_ind` enters halt. From halt, a low `halt_ind` returns to system-management if `smm_ind` is high and to run otherwise. In halt, an accepted snoop takes priority over `stop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the control logic (never gated) |
| rst | input | 1 | Synchronous reset, active high |
| stop_req | input | 1 | Stop-clock request, level |
| init_req | input | 1 | Init request |
| halt_ind | input | 1 | Core reports that it has halted |
| smm_ind | input | 1 | Core is in system-management mode |
| ahold | input | 1 | Address hold asserted by system logic |
| boff | input | 1 | Back-off asserted by system logic |
| hlda | input | 1 | Hold acknowledge given to system logic |
| snoop_strobe | input | 1 | Snoop address strobe |
| tag_hit | input | 1 | Tag lookup result: line present |
| tag_dirty | input | 1 | Tag lookup result: line modified |
| state_out | output | 3 | Power state: 0 run, 1 system-management, 2 halt, 3 stop-grant, 4 inquire |
| core_clk_en | output | 1 | Enable for the gated core clock |
| dbus_oe | output | DATA_W | Data bus output enables |
| par_oe | output | PAR_W | Data parity output enables |
| hit_out | output | 1 | Snoop hit on a clean line |
| hitm_out | output | 1 | Snoop hit on a modified line |
| wb_req | output | 1 | Writeback request for the modified line |
| init_act | output | 1 | One-cycle init action pulse |

## Verification
The assertions assume that system logic raises `snoop_strobe` only while it holds the bus. They also assume the lookup inputs are valid in the cycle after an accepted strobe, and that no second strobe arrives while an inquire is still open. The stimulus follows these rules: every strobe is a single cycle driven with exactly one hold signal set, the tag inputs are driven only in the lookup cycle, and each inquire is allowed to finish before the next one starts. The two deliberately unaccepted strobes are the exception; they are sent outside halt and stop-grant, or with no hold signal, to show that they are ignored.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_SMM   = 3'd1,
    PS_HALT  = 3'd2,
    PS_STOPG = 3'd3,
    PS_INQ   = 3'd4
  } pstate_e;

  typedef enum logic [2:0] {
    SN_IDLE, SN_LOOK, SN_FIN, SN_WAIT, SN_WB
  } sphase_e;

  // Context resumed when neither halt nor stop applies.
  function automatic pstate_e active_ctx(input logic smm);
    return smm ? PS_SMM : PS_RUN;
  endfunction

  // The core clock runs only in the two executing contexts.
  function automatic logic core_runs(input pstate_e s);
    return (s == PS_RUN) || (s == PS_SMM);
  endfunction

  function automatic logic bus_held(input logic ah, input logic bo, input logic hl);
    return ah | bo | hl;
  endfunction
endpackage

// File: rtl/psc_ctx.sv
module psc_ctx
  import psc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    stop_req,
  input  logic    halt_ind,
  input  logic    smm_ind,
  input  logic    snoop_strobe,
  input  logic    held,
  input  logic    snoop_done,
  output pstate_e state,
  output logic    snoop_go,
  output logic    entering_stop,
  output logic    stop_exit,
  output logic    in_stop
);
  pstate_e nxt, ret_stop, ret_inq;

  assign snoop_go = snoop_strobe && held &&
                    ((state == PS_HALT) || (state == PS_STOPG));
  assign stop_exit = (state == PS_STOPG) && !snoop_go && !stop_req;
  assign in_stop   = (state == PS_STOPG) ||
                     ((state == PS_INQ) && (ret_inq == PS_STOPG));
  assign entering_stop = (nxt == PS_STOPG) && !in_stop && (state != PS_INQ);

  always_comb begin
    nxt = state;
    unique case (state)
      PS_RUN, PS_SMM: begin
        if (stop_req)      nxt = PS_STOPG;
        else if (halt_ind) nxt = PS_HALT;
        else               nxt = active_ctx(smm_ind);
      end
      PS_HALT: begin
        if (snoop_go)       nxt = PS_INQ;
        else if (stop_req)  nxt = PS_STOPG;
        else if (!halt_ind) nxt = active_ctx(smm_ind);
      end
      PS_STOPG: begin
        if (snoop_go)       nxt = PS_INQ;
        else if (!stop_req) nxt = ret_stop;
      end
      PS_INQ: begin
        if (snoop_done) nxt = ret_inq;
      end
      default: nxt = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PS_RUN;
      ret_stop <= PS_RUN;
      ret_inq  <= PS_HALT;
    end else begin
      state <= nxt;
      if (entering_stop) ret_stop <= state;
      if (snoop_go)      ret_inq  <= state;
    end
  end

  a_r2_stop_enters: assert property (@(posedge clk) disable iff (rst)
    (core_runs(state) && stop_req) |=> (state == PS_STOPG));
  a_r3_return_entry: assert property (@(posedge clk) disable iff (rst)
    ((state == PS_STOPG) && !stop_req && !snoop_go) |=> (state == $past(ret_stop)));
  a_r7_no_snoop_active: assert property (@(posedge clk) disable iff (rst)
    core_runs(state) |=> (state != PS_INQ));
endmodule

// File: rtl/psc_init_hold.sv
module psc_init_hold (
  input  logic clk,
  input  logic rst,
  input  logic init_req,
  input  logic in_stop,
  input  logic entering_stop,
  input  logic stop_exit,
  output logic init_act
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      init_act <= 1'b0;
    end else begin
      init_act <= 1'b0;
      if (stop_exit) begin
        init_act <= pend | init_req;
        pend     <= 1'b0;
      end else if (in_stop || entering_stop) begin
        if (init_req) pend <= 1'b1;
      end else begin
        init_act <= init_req;
      end
    end
  end

  a_r5_no_act_in_stop: assert property (@(posedge clk) disable iff (rst)
    in_stop |-> !init_act);
endmodule

// File: rtl/psc_snoop.sv
module psc_snoop
  import psc_pkg::*;
#(
  parameter int WB_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ahold,
  input  logic boff,
  input  logic hlda,
  input  logic tag_hit,
  input  logic tag_dirty,
  output logic hit_out,
  output logic hitm_out,
  output logic wb_req,
  output logic done
);
  localparam int CW = $clog2(WB_CYC + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WB_CYC - 1);

  sphase_e       phase;
  logic [CW-1:0] cnt;
  logic          imm;
  logic          released;

  assign released = !boff && !hlda;
  assign done = (phase == SN_FIN) || ((phase == SN_WB) && (cnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= SN_IDLE;
      cnt      <= '0;
      imm      <= 1'b0;
      hit_out  <= 1'b0;
      hitm_out <= 1'b0;
      wb_req   <= 1'b0;
    end else begin
      unique case (phase)
        SN_IDLE: if (start) begin
          phase <= SN_LOOK;
          imm   <= ahold;
        end
        SN_LOOK: begin
          if (tag_hit && tag_dirty) begin
            hitm_out <= 1'b1;
            if (imm) begin
              phase  <= SN_WB;
              wb_req <= 1'b1;
              cnt    <= CNT_LOAD;
            end else begin
              phase <= SN_WAIT;
            end
          end else begin
            hit_out <= tag_hit;
            phase   <= SN_FIN;
          end
        end
        SN_FIN: begin
          hit_out <= 1'b0;
          phase   <= SN_IDLE;
        end
        SN_WAIT: if (released) begin
          phase  <= SN_WB;
          wb_req <= 1'b1;
          cnt    <= CNT_LOAD;
        end
        SN_WB: begin
          if (cnt == '0) begin
            hitm_out <= 1'b0;
            wb_req   <= 1'b0;
            phase    <= SN_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= SN_IDLE;
      endcase
    end
  end

  a_r10_wb_under_hitm: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> hitm_out);
  a_r9_hit_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_out, hitm_out}));
  a_r11_deferred_wb: assert property (@(posedge clk) disable iff (rst)
    (phase == SN_WAIT) |-> !wb_req);
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
  import psc_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PAR_W  = 8,
  parameter int WB_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              init_req,
  input  logic              halt_ind,
  input  logic              smm_ind,
  input  logic              ahold,
  input  logic              boff,
  input  logic              hlda,
  input  logic              snoop_strobe,
  input  logic              tag_hit,
  input  logic              tag_dirty,
  output logic [2:0]        state_out,
  output logic              core_clk_en,
  output logic [DATA_W-1:0] dbus_oe,
  output logic [PAR_W-1:0]  par_oe,
  output logic              hit_out,
  output logic              hitm_out,
  output logic              wb_req,
  output logic              init_act
);
  pstate_e state;
  logic snoop_go, snoop_done, entering_stop, stop_exit, in_stop;
  logic drive_ok;

  psc_ctx u_ctx (
    .clk(clk), .rst(rst), .stop_req(stop_req), .halt_ind(halt_ind),
    .smm_ind(smm_ind), .snoop_strobe(snoop_strobe),
    .held(bus_held(ahold, boff, hlda)), .snoop_done(snoop_done),
    .state(state), .snoop_go(snoop_go), .entering_stop(entering_stop),
    .stop_exit(stop_exit), .in_stop(in_stop)
  );

  psc_init_hold u_init (
    .clk(clk), .rst(rst), .init_req(init_req), .in_stop(in_stop),
    .entering_stop(entering_stop), .stop_exit(stop_exit), .init_act(init_act)
  );

  psc_snoop #(.WB_CYC(WB_CYC)) u_snoop (
    .clk(clk), .rst(rst), .start(snoop_go), .ahold(ahold), .boff(boff),
    .hlda(hlda), .tag_hit(tag_hit), .tag_dirty(tag_dirty),
    .hit_out(hit_out), .hitm_out(hitm_out), .wb_req(wb_req), .done(snoop_done)
  );

  assign state_out   = state;
  assign core_clk_en = core_runs(state);
  assign drive_ok    = !in_stop || wb_req;

  for (genvar i = 0; i < DATA_W; i++) begin : g_doe
    assign dbus_oe[i] = drive_ok;
  end
  for (genvar j = 0; j < PAR_W; j++) begin : g_poe
    assign par_oe[j] = drive_ok;
  end

  a_r4_float_in_stop: assert property (@(posedge clk) disable iff (rst)
    (in_stop && !wb_req) |-> ((dbus_oe == '0) && (par_oe == '0)));
  a_r8_return_with_hitm: assert property (@(posedge clk) disable iff (rst)
    $fell(hitm_out) |-> (state != PS_INQ));
  a_r2_clk_gated: assert property (@(posedge clk) disable iff (rst)
    (state == PS_STOPG) |-> !core_clk_en);
endmodule

// File: tb/sim_stopclk_ctrl.sv
module sim_stopclk_ctrl;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst, stop_req, init_req, halt_ind, smm_ind, ahold, boff, hlda;
  logic snoop_strobe, tag_hit, tag_dirty;
  logic [2:0]  state_out;
  logic        core_clk_en, hit_out, hitm_out, wb_req, init_act;
  logic [63:0] dbus_oe;
  logic [7:0]  par_oe;
  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  always #(PERIOD / 2) clk = ~clk;

  stopclk_ctrl u0 (
    .clk(clk), .rst(rst), .stop_req(stop_req), .init_req(init_req),
    .halt_ind(halt_ind), .smm_ind(smm_ind), .ahold(ahold), .boff(boff),
    .hlda(hlda), .snoop_strobe(snoop_strobe), .tag_hit(tag_hit),
    .tag_dirty(tag_dirty), .state_out(state_out), .core_clk_en(core_clk_en),
    .dbus_oe(dbus_oe), .par_oe(par_oe), .hit_out(hit_out), .hitm_out(hitm_out),
    .wb_req(wb_req), .init_act(init_act)
  );

  // {stop, halt, smm, init, expected state[2:0], expected init_act}
  localparam logic [7:0] VEC [16] = '{
    8'b0000_000_0, 8'b0001_000_1, 8'b0010_001_0, 8'b1010_011_0,
    8'b1011_011_0, 8'b1010_011_0, 8'b0010_001_1, 8'b0000_000_0,
    8'b0100_010_0, 8'b1100_011_0, 8'b1000_011_0, 8'b0100_010_0,
    8'b0000_000_0, 8'b1001_011_0, 8'b0000_000_1, 8'b0000_000_0
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic oe_chk(input string tag, input logic exp);
    chk(tag, {30'b0, &dbus_oe, &par_oe}, exp ? 32'd3 : 32'd0);
    chk(tag, {30'b0, |dbus_oe, |par_oe}, exp ? 32'd3 : 32'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; stop_req = 0; init_req = 0; halt_ind = 0; smm_ind = 0;
    ahold = 0; boff = 0; hlda = 0; snoop_strobe = 0; tag_hit = 0; tag_dirty = 0;
    @(negedge clk);
    step(); step();
    // R1 reset state
    chk("R1 state", 32'(state_out), 0);
    chk("R1 clk_en", 32'(core_clk_en), 1);
    chk("R1 strobes", {28'b0, hit_out, hitm_out, wb_req, init_act}, 0);
    oe_chk("R1 oe", 1'b1);
    rst = 0;
    step();
    chk("R1 after release", 32'(state_out), 0);

    // Context walk: R2 R3 R5 R12
    for (int i = 0; i < 16; i++) begin
      {stop_req, halt_ind, smm_ind, init_req} = VEC[i][7:4];
      step();
      chk($sformatf("R2/R3/R12 vec %0d state", i), 32'(state_out), 32'(VEC[i][3:1]));
      chk($sformatf("R5 vec %0d init_act", i), 32'(init_act), 32'(VEC[i][0]));
      chk($sformatf("R2 vec %0d clk_en", i), 32'(core_clk_en),
          (VEC[i][3:1] <= 3'd1) ? 32'd1 : 32'd0);
      oe_chk($sformatf("R4 vec %0d", i), VEC[i][3:1] != 3'd3);
    end

    // R7 strobe ignored in run
    snoop_strobe = 1; ahold = 1; step();
    chk("R7 run ignores strobe", 32'(state_out), 0);
    snoop_strobe = 0; ahold = 0; step();
    chk("R7 run no hit", {30'b0, hit_out, hitm_out}, 0);
    // R7 strobe ignored in halt without bus hold
    halt_ind = 1; step();
    snoop_strobe = 1; step();
    chk("R7 halt unheld ignored", 32'(state_out), 2);
    snoop_strobe = 0;

    // R9 clean hit from halt under back-off
    boff = 1; snoop_strobe = 1; step();
    chk("R7 inquire entry", 32'(state_out), 4);
    snoop_strobe = 0; tag_hit = 1; step();
    tag_hit = 0;
    chk("R9 hit high", {30'b0, hit_out, hitm_out}, 32'd2);
    chk("R9 still inquire", 32'(state_out), 4);
    oe_chk("R4 inquire from halt driven", 1'b1);
    step();
    chk("R9 hit low", 32'(hit_out), 0);
    chk("R9 back to halt", 32'(state_out), 2);
    boff = 0;

    // R12 snoop beats stop in halt; R8 miss
    ahold = 1; snoop_strobe = 1; stop_req = 1; step();
    chk("R12 snoop priority", 32'(state_out), 4);
    snoop_strobe = 0; step();
    chk("R8 miss no hit", {30'b0, hit_out, hitm_out}, 0);
    chk("R8 inquire one", 32'(state_out), 4);
    step();
    chk("R8 return halt", 32'(state_out), 2);
    step();
    chk("R12 then stop", 32'(state_out), 3);
    oe_chk("R4 float stop", 1'b0);

    // R10 dirty hit under address hold
    snoop_strobe = 1; step();
    chk("R10 inquire", 32'(state_out), 4);
    oe_chk("R4 float inquire", 1'b0);
    snoop_strobe = 0; tag_hit = 1; tag_dirty = 1; step();
    tag_hit = 0; tag_dirty = 0;
    chk("R10 hitm wb", {30'b0, hitm_out, wb_req}, 32'd3);
    oe_chk("R4 driven for wb", 1'b1);
    step(); step(); step();
    chk("R10 wb last", {29'b0, hitm_out, wb_req, state_out == 3'd4}, 32'd7);
    step();
    chk("R10 hitm falls", {30'b0, hitm_out, wb_req}, 0);
    chk("R10 return stop", 32'(state_out), 3);
    ahold = 0;

    // R11 dirty hit under hold acknowledge
    hlda = 1; snoop_strobe = 1; step();
    snoop_strobe = 0; tag_hit = 1; tag_dirty = 1; step();
    tag_hit = 0; tag_dirty = 0;
    chk("R11 hitm no wb", {30'b0, hitm_out, wb_req}, 32'd2);
    step(); step();
    chk("R11 still waiting", {29'b0, hitm_out, wb_req, state_out == 3'd4}, 32'd5);
    oe_chk("R11 float waiting", 1'b0);
    hlda = 0; step();
    chk("R11 wb starts", {30'b0, hitm_out, wb_req}, 32'd3);
    step(); step(); step();
    chk("R11 wb held", 32'(wb_req), 1);
    step();
    chk("R11 done", {30'b0, hitm_out, wb_req}, 0);
    chk("R11 return stop", 32'(state_out), 3);

    // R3 return to halt, then run
    stop_req = 0; step();
    chk("R3 back to halt", 32'(state_out), 2);
    halt_ind = 0; step();
    chk("R12 halt exit run", 32'(state_out), 0);

    // R6 reset clears deferred init
    stop_req = 1; step();
    init_req = 1; step();
    init_req = 0;
    chk("R5 deferred", 32'(init_act), 0);
    rst = 1; step();
    chk("R6 reset to run", 32'(state_out), 0);
    rst = 0; step();
    chk("R6 after reset enters stop", 32'(state_out), 3);
    stop_req = 0; step();
    chk("R6 pending cleared", 32'(init_act), 0);

    // R6 reset from inquire
    stop_req = 1; step();
    ahold = 1; snoop_strobe = 1; step();
    snoop_strobe = 0; rst = 1; step();
    chk("R6 inquire reset", {28'b0, state_out == 3'd0, hitm_out, hit_out, wb_req}, 32'd8);
    rst = 0; ahold = 0; step();

    // R5 deferral with release
    step();
    init_req = 1; step();
    init_req = 0; step();
    chk("R5 no pulse while stopped", 32'(init_act), 0);
    stop_req = 0; step();
    chk("R5 pulse on exit", {30'b0, init_act, state_out == 3'd0}, 32'd3);
    step();
    chk("R5 pulse one cycle", 32'(init_act), 0);

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule